// File: doc/BRIEF.md
# SAR ADC Controller

This block controls a successive-approximation analog-to-digital converter that has up to eight multiplexed inputs. Software reaches it through a small bus with an address phase and an access phase. Four word registers are visible: the last result, a busy flag, a control word and a power-up delay. A control write that sets the power bit turns on the converter and latches the input channel. The block then waits for the programmed number of clock periods and runs one conversion. When the conversion ends it stores the result, sets a completion flag and, if enabled, raises an interrupt.

The conversion engine is part of the block. Each clock it places a trial code on the DAC port and keeps or drops the trial bit according to the external comparator. A control write of zero acknowledges the interrupt and powers the converter down. The same write also cancels a sequence that is still running.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads 0, `adc_pwr_o`, `irq_o` and `dac_code_o` are 0, `chan_sel_o` is 0 and `pready_o` is 1.
- R2: Word offsets are 0x00 result, 0x04 flags, 0x08 control and 0x0C delay. The control word puts the channel in bits [2:0], power in bit 3, interrupt enable in bit 5 and completion flag in bit 6; all other bits read 0. The result and flags registers ignore writes. Any other offset, misaligned ones included, reads 0 and ignores writes.
- R3: The delay register keeps bits [5:0] of a write and reads them back. Upper bits read 0.
- R4: A control write with bit 3 set while idle powers up (`adc_pwr_o`=1), puts the channel on `chan_sel_o` and sets flags bit 0 (busy). With delay D loaded, the conversion begins D+1 cycles after the write edge and completes RES_W cycles after that. Power stays on throughout the sequence.
- R5: During a conversion `dac_code_o` shows the kept bits OR the bit under trial, starting with the MSB and resolving one bit per clock. A bit is kept when `cmp_i` is 1 at the following edge. The code is 0 whenever no conversion runs.
- R6: On the completing edge the result register takes the code, right-aligned and zero-extended. Control bit 6 sets and busy falls on that same edge.
- R7: `irq_o` is high exactly when control bits 6 and 5 are both set. An idle control write clears bit 6 when its data bit 6 is 0 and keeps it when data bit 6 is 1.
- R8: A nonzero control write while busy changes only the interrupt enable. The channel, the power bit and the running conversion are not affected.
- R9: A control write of all zeros clears the control word, so the flag is cleared and power is off. If a sequence is running it is cancelled on that edge, busy falls and the result register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also counts the delay and paces the conversion |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write (1) or read (0) |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data |
| pready_o | output | 1 | Transfer complete, always 1 |
| dac_code_o | output | RES_W | Trial code to the DAC |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| chan_sel_o | output | 3 | Input multiplexer select |
| adc_pwr_o | output | 1 | Converter power enable |
| irq_o | output | 1 | Completion interrupt |

## Verification
On every cycle the assertions check the following: power is on whenever busy is high, the DAC code is zero outside a conversion, and the channel holds steady through a sequence. They also check that busy falls without a cancel only when the completion flag sets, that the interrupt rises only at completion or after a control write, and that a zero write leaves the block idle and unpowered. Other properties need the bench's scenarios, which pair a comparator model with known input levels. These are the exact cycle at which the first trial code appears and the interrupt rises for a given delay, and whether the result equals the analog level. Register read-back, writes to read-only or unmapped offsets, and a result that survives a cancel are also shown only by the bench.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int unsigned OFS_DATA = 32'h00;
  localparam int unsigned OFS_STAT = 32'h04;
  localparam int unsigned OFS_CTRL = 32'h08;
  localparam int unsigned OFS_DLY  = 32'h0C;
  localparam int unsigned CH_W     = 3;
  localparam int unsigned CTRL_PWR = 3;
  localparam int unsigned CTRL_IEN = 5;
  localparam int unsigned CTRL_IST = 6;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WAIT, SEQ_CONV} seq_state_e;
endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int unsigned DLY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             abort_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             conv_done_i,
  output logic             busy_o,
  output logic             eng_start_o
);
  seq_state_e       state_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (abort_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (go_i) begin
          state_q <= SEQ_WAIT;
          cnt_q   <= dly_i;
        end
        SEQ_WAIT: begin
          if (cnt_q == '0) state_q <= SEQ_CONV;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        SEQ_CONV: if (conv_done_i) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != SEQ_IDLE);
  assign eng_start_o = (state_q == SEQ_WAIT) && (cnt_q == '0) && !abort_i;
endmodule

// File: rtl/sar_adc_engine.sv
module sar_adc_engine #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] trial;

  assign trial      = active_q ? (acc_q | (RES_W'(1) << idx_q)) : '0;
  assign dac_code_o = trial;
  assign result_o   = cmp_i ? trial : acc_q;
  assign done_o     = active_q && (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      acc_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      acc_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= IDX_W'(RES_W - 1);
      acc_q    <= '0;
    end else if (active_q) begin
      acc_q <= result_o;
      if (idx_q == '0) active_q <= 1'b0;
      else             idx_q    <= idx_q - 1'b1;
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned DLY_W  = 6,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic [RES_W-1:0]  dac_code_o,
  input  logic              cmp_i,
  output logic [CH_W-1:0]   chan_sel_o,
  output logic              adc_pwr_o,
  output logic              irq_o
);
  logic [RES_W-1:0] data_q;
  logic [CH_W-1:0]  chan_q;
  logic             pwr_q, ien_q, ist_q;
  logic [DLY_W-1:0] dly_q;

  logic             wr_en, ctrl_wr, dly_wr, abort, go, busy;
  logic             eng_start, eng_done;
  logic [RES_W-1:0] eng_result;

  assign wr_en   = psel_i && penable_i && pwrite_i;
  assign ctrl_wr = wr_en && (paddr_i == ADDR_W'(OFS_CTRL));
  assign dly_wr  = wr_en && (paddr_i == ADDR_W'(OFS_DLY));
  assign abort   = ctrl_wr && busy && (pwdata_i == '0);
  assign go      = ctrl_wr && !busy && pwdata_i[CTRL_PWR];

  sar_adc_seq #(.DLY_W(DLY_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .abort_i     (abort),
    .dly_i       (dly_q),
    .conv_done_i (eng_done),
    .busy_o      (busy),
    .eng_start_o (eng_start)
  );

  sar_adc_engine #(.RES_W(RES_W)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (eng_start),
    .abort_i    (abort),
    .cmp_i      (cmp_i),
    .dac_code_o (dac_code_o),
    .done_o     (eng_done),
    .result_o   (eng_result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      chan_q <= '0;
      pwr_q  <= 1'b0;
      ien_q  <= 1'b0;
      ist_q  <= 1'b0;
      dly_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        if (abort) begin
          chan_q <= '0;
          pwr_q  <= 1'b0;
          ien_q  <= 1'b0;
          ist_q  <= 1'b0;
        end else if (busy) begin
          ien_q <= pwdata_i[CTRL_IEN];
        end else begin
          chan_q <= pwdata_i[CH_W-1:0];
          pwr_q  <= pwdata_i[CTRL_PWR];
          ien_q  <= pwdata_i[CTRL_IEN];
          ist_q  <= ist_q && pwdata_i[CTRL_IST];
        end
      end
      // completion wins over a busy-time enable write, loses to a cancel
      if (eng_done && !abort) begin
        data_q <= eng_result;
        ist_q  <= 1'b1;
      end
      if (dly_wr) dly_q <= pwdata_i[DLY_W-1:0];
    end
  end

  always_comb begin
    prdata_o = '0;
    unique case (paddr_i)
      ADDR_W'(OFS_DATA): prdata_o = DATA_W'(data_q);
      ADDR_W'(OFS_STAT): prdata_o = DATA_W'(busy);
      ADDR_W'(OFS_CTRL): begin
        prdata_o[CH_W-1:0] = chan_q;
        prdata_o[CTRL_PWR] = pwr_q;
        prdata_o[CTRL_IEN] = ien_q;
        prdata_o[CTRL_IST] = ist_q;
      end
      ADDR_W'(OFS_DLY):  prdata_o = DATA_W'(dly_q);
      default:           prdata_o = '0;
    endcase
  end

  assign pready_o   = 1'b1;
  assign chan_sel_o = chan_q;
  assign adc_pwr_o  = pwr_q;
  assign irq_o      = ist_q && ien_q;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             abort_i,
  input logic             ctrl_wr_i,
  input logic             ist_i,
  input logic             irq_i,
  input logic [RES_W-1:0] dac_code_i,
  input logic [CH_W-1:0]  chan_sel_i,
  input logic             adc_pwr_i
);
  a_r4_power_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> adc_pwr_i);

  a_r5_code_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (dac_code_i == '0));

  a_r8_chan_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(chan_sel_i));

  a_r6_done_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && !$past(abort_i)) |-> ist_i);

  a_r7_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> ($fell(busy_i) || $past(ctrl_wr_i)));

  a_r9_cancel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_i && !adc_pwr_i));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy),
  .abort_i    (abort),
  .ctrl_wr_i  (ctrl_wr),
  .ist_i      (ist_q),
  .irq_i      (irq_o),
  .dac_code_i (dac_code_o),
  .chan_sel_i (chan_sel_o),
  .adc_pwr_i  (adc_pwr_o)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  localparam int unsigned RES_W = 10;
  localparam logic [7:0] A_DATA = 8'h00, A_STAT = 8'h04, A_CTRL = 8'h08, A_DLY = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, adc_pwr, irq, cmp;
  logic [RES_W-1:0] dac_code;
  logic [RES_W-1:0] vin = '0;
  logic [2:0] chan_sel;
  int nchk = 0, nerr = 0;
  bit fin = 1'b0;

  always #10 clk = ~clk;
  assign cmp = (dac_code <= vin);

  sar_adc_ctrl #(.RES_W(RES_W)) i_sar_adc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .dac_code_o(dac_code), .cmp_i(cmp), .chan_sel_o(chan_sel), .adc_pwr_o(adc_pwr), .irq_o(irq)
  );

  function automatic logic [31:0] exp_ctrl(input logic [2:0] ch, input logic pw, input logic ie, input logic st);
    return {25'b0, st, ie, 1'b0, pw, ch};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic run_conv(input logic [2:0] ch, input logic [5:0] d, input logic [RES_W-1:0] v, input logic ie);
    logic [31:0] r;
    vin = v;
    bus_wr(A_DLY, {26'b0, d});
    bus_wr(A_CTRL, exp_ctrl(ch, 1'b1, ie, 1'b0));
    chk("R4 power on", {31'b0, adc_pwr}, 1);
    chk("R4 channel", {29'b0, chan_sel}, {29'b0, ch});
    repeat (int'(d) + 1) @(negedge clk);
    chk("R5 first trial msb", {22'b0, dac_code}, 32'(1) << (RES_W - 1));
    repeat (RES_W - 1) @(negedge clk);
    chk("R6 irq not before last bit", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R7 irq at completion", {31'b0, irq}, {31'b0, ie});
    chk("R5 code idle", {22'b0, dac_code}, 0);
    bus_rd(A_DATA, r); chk("R6 result", r, {22'b0, v});
    bus_rd(A_STAT, r); chk("R6 busy low", r, 0);
    bus_rd(A_CTRL, r); chk("R2 ctrl readback", r, exp_ctrl(ch, 1'b1, ie, 1'b1));
    bus_wr(A_CTRL, 0);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    chk("R9 power off", {31'b0, adc_pwr}, 0);
  endtask

  initial begin
    logic [31:0] r;
    logic [RES_W-1:0] last;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_rd(A_DATA, r); chk("R1 data", r, 0);
    bus_rd(A_STAT, r); chk("R1 stat", r, 0);
    bus_rd(A_CTRL, r); chk("R1 ctrl", r, 0);
    bus_rd(A_DLY, r);  chk("R1 dly", r, 0);
    chk("R1 pins", {27'b0, pready, adc_pwr, irq, chan_sel == 3'd0, dac_code == '0}, 32'h13);

    // R3 delay width
    bus_wr(A_DLY, 32'hFFFF_FFFF);
    bus_rd(A_DLY, r); chk("R3 delay 6 bits", r, 32'h3F);

    // directed corners
    run_conv(3'd0, 6'd8, 10'h2A5, 1'b1);
    run_conv(3'd7, 6'd0, 10'h3FF, 1'b1);
    run_conv(3'd2, 6'd63, 10'h000, 1'b0);
    run_conv(3'd5, 6'd1, 10'h200, 1'b1);
    for (int i = 0; i < 8; i++)
      run_conv(3'($urandom % 8), 6'($urandom % 20), RES_W'($urandom), 1'($urandom));
    last = vin;

    // R2 read-only and unmapped offsets
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_wr(A_DATA, 32'hFFFF_FFFF);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_wr(8'h09, 32'hFFFF_FFFF);
    chk("R2 no power from stray write", {31'b0, adc_pwr}, 0);
    bus_rd(A_DATA, r); chk("R2 data write ignored", r, {22'b0, last});
    bus_rd(A_STAT, r); chk("R2 stat write ignored", r, 0);
    bus_rd(A_CTRL, r); chk("R2 ctrl untouched", r, 0);
    bus_rd(8'h10, r);  chk("R2 unmapped reads 0", r, 0);
    bus_rd(8'h09, r);  chk("R2 misaligned reads 0", r, 0);

    // R9 cancel during delay
    vin = 10'h155;
    bus_wr(A_DLY, 40);
    bus_wr(A_CTRL, exp_ctrl(3'd3, 1'b1, 1'b1, 1'b0));
    repeat (5) @(negedge clk);
    bus_wr(A_CTRL, 0);
    chk("R9 cancel power off", {31'b0, adc_pwr}, 0);
    bus_rd(A_STAT, r); chk("R9 cancel busy low", r, 0);
    repeat (60) @(negedge clk);
    chk("R9 no irq after cancel", {31'b0, irq}, 0);
    bus_rd(A_DATA, r); chk("R9 result kept (delay)", r, {22'b0, last});

    // R9 cancel during conversion
    bus_wr(A_DLY, 0);
    bus_wr(A_CTRL, exp_ctrl(3'd1, 1'b1, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    bus_wr(A_CTRL, 0);
    chk("R9 code zero after cancel", {22'b0, dac_code}, 0);
    repeat (20) @(negedge clk);
    bus_rd(A_DATA, r); chk("R9 result kept (conv)", r, {22'b0, last});
    bus_rd(A_CTRL, r); chk("R9 ctrl cleared", r, 0);

    // R8 write while busy
    vin = 10'h0F3;
    bus_wr(A_DLY, 30);
    bus_wr(A_CTRL, exp_ctrl(3'd5, 1'b1, 1'b1, 1'b0));
    bus_wr(A_CTRL, exp_ctrl(3'd2, 1'b0, 1'b0, 1'b0));
    chk("R8 channel held", {29'b0, chan_sel}, 5);
    chk("R8 power held", {31'b0, adc_pwr}, 1);
    repeat (45) @(negedge clk);
    chk("R8 enable cleared, no irq", {31'b0, irq}, 0);
    bus_rd(A_CTRL, r); chk("R8 ctrl after busy write", r, exp_ctrl(3'd5, 1'b1, 1'b0, 1'b1));
    bus_rd(A_DATA, r); chk("R8 conversion finished", r, 32'h0F3);

    // R7 flag keep and clear on idle writes
    bus_wr(A_CTRL, exp_ctrl(3'd0, 1'b0, 1'b1, 1'b1));
    chk("R7 flag kept, irq on", {31'b0, irq}, 1);
    chk("R7 no start without power", {31'b0, adc_pwr}, 0);
    bus_rd(A_CTRL, r); chk("R7 ctrl kept flag", r, exp_ctrl(3'd0, 1'b0, 1'b1, 1'b1));
    bus_wr(A_CTRL, exp_ctrl(3'd0, 1'b0, 1'b1, 1'b0));
    chk("R7 flag cleared, irq off", {31'b0, irq}, 0);

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      nerr++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule